// File: doc/BRIEF.md
# Two-Thread Partitioned Micro-Op Queue

This block is a shared in-order buffer that sits between a producing pipeline stage and a consuming stage when two hardware threads share the machine. Each thread has its own enqueue handshake. The queue takes at most one entry per cycle on the enqueue side. It hands out at most one entry per cycle on a single dequeue port, and every dequeued entry is tagged with the thread that wrote it. Within a thread, entries leave in the order they arrived. The two threads have no ordering relative to each other.

A mode request selects how the storage is shared. In split mode each thread owns one half of the entries, and a thread whose half is full is held off even when the other half has room. In solo mode thread 0 is the only active thread and may fill every entry, while thread 1 is held off. On both the enqueue side and the dequeue side, when both threads compete, the thread not served on the previous transfer wins. A thread with nothing to offer gives its turn to the other thread, so no slot is wasted. A change of mode takes effect only once the queue is empty. While the change is waiting, enqueues are refused so that the queue drains.

Top module: `dual_thread_uop_queue`

## Requirements
- R1: In split mode (`mode_st` = 0) each thread holds at most DEPTH/2 entries. A thread at that limit sees its ready low, and the other thread is still accepted if its own half has room.
- R2: In solo mode (`mode_st` = 1) thread 0 is accepted until it holds DEPTH entries, and `t1_in_ready` stays low.
- R3: Entries of one thread are dequeued in the order they were accepted. `deq_tid` carries the owning thread (0 or 1) and `deq_data` carries the payload written by that thread.
- R4: When both threads hold entries, a dequeue serves the thread not served by the previous dequeue. If only one thread holds entries, that thread is served every cycle. After reset thread 0 is served first.
- R5: At most one enqueue is accepted per cycle. When both threads request and have room, the thread not accepted last wins, and the other sees its ready low. A lone requester is accepted. After reset thread 0 wins the first tie.
- R6: `mode_req` (1 = solo, 0 = split) is applied only at a clock edge where the queue is empty. While `mode_req` differs from `mode_st`, both ready outputs are low and dequeues continue.
- R7: After reset the queue is empty, `deq_valid` is 0, `mode_st` is 0, and with no competing request both ready outputs are 1.
- R8: An entry accepted at a clock edge into an empty thread is presented on the dequeue port in the cycle right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 1 | Requested mode: 1 solo, 0 split |
| mode_st | output | 1 | Mode in force: 1 solo, 0 split |
| t0_in_valid | input | 1 | Thread 0 offers an entry |
| t0_in_data | input | PAYLOAD_W | Thread 0 payload |
| t0_in_ready | output | 1 | Thread 0 entry is taken this cycle if valid |
| t1_in_valid | input | 1 | Thread 1 offers an entry |
| t1_in_data | input | PAYLOAD_W | Thread 1 payload |
| t1_in_ready | output | 1 | Thread 1 entry is taken this cycle if valid |
| deq_valid | output | 1 | An entry is presented |
| deq_tid | output | 1 | Owning thread of the presented entry |
| deq_data | output | PAYLOAD_W | Payload of the presented entry |
| deq_ready | input | 1 | Consumer takes the presented entry |

## Verification
Both ready outputs follow the current inputs and state within the same cycle, so the bench drives its inputs just after a rising edge and reads the ready values at the following falling edge, before the edge that accepts. An accepted entry appears on the dequeue port one edge later, so it is checked at the falling edge after the accepting edge. A mode change needs one edge at which the queue is already empty. The bench therefore checks that `mode_st` is unchanged just after the last entry drains and that it has changed one edge later.

// File: rtl/dtq_pkg.sv
package dtq_pkg;

    typedef enum logic {
        TID0 = 1'b0,
        TID1 = 1'b1
    } tid_e;

    typedef enum logic {
        MODE_SPLIT = 1'b0,
        MODE_SOLO  = 1'b1
    } mode_e;

    // index of the other thread
    function automatic int unsigned peer(input int unsigned t);
        return (t == 0) ? 1 : 0;
    endfunction

endpackage

// File: rtl/dtq_rr_arb.sv
module dtq_rr_arb
    import dtq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] req,
    input  logic       fire,
    output logic [1:0] gnt,
    output tid_e       last_q
);

    always_comb begin
        if (req == 2'b11) begin
            gnt = (last_q == TID0) ? 2'b10 : 2'b01;
        end else begin
            gnt = req;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= TID1;
        end else if (fire) begin
            last_q <= tid_e'(gnt[1]);
        end
    end

    AST_GNT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt)); // R5

    AST_RR_TURN: assert property (@(posedge clk) disable iff (rst)
        (req == 2'b11) |-> (gnt[last_q] == 1'b0)); // R4

endmodule

// File: rtl/dtq_thread_ctl.sv
module dtq_thread_ctl
    import dtq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TID   = 0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  mode_e                    mode,
    input  logic                     push,
    input  logic                     pop,
    output logic [$clog2(DEPTH)-1:0] wr_addr,
    output logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic                     room,
    output logic                     nonempty
);

    localparam int AW   = $clog2(DEPTH);
    localparam int HAW  = AW - 1;
    localparam int HALF = DEPTH / 2;
    localparam int CW   = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] LIM_HALF = CW'(HALF);
    localparam logic [CW-1:0] LIM_SOLO = (TID == 0) ? CW'(DEPTH) : '0;

    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p, input mode_e m);
        logic [HAW-1:0] lo;
        if (m == MODE_SOLO) begin
            return p + 1'b1;
        end
        lo = p[HAW-1:0] + 1'b1;
        return {1'b0, lo};
    endfunction

    function automatic logic [AW-1:0] place(input logic [AW-1:0] p, input mode_e m);
        if (m == MODE_SOLO) begin
            return p;
        end
        return {TID[0], p[HAW-1:0]};
    endfunction

    assign limit    = (mode == MODE_SOLO) ? LIM_SOLO : LIM_HALF;
    assign room     = (cnt_q < limit);
    assign nonempty = (cnt_q != '0);
    assign wr_addr  = place(wr_q, mode);
    assign rd_addr  = place(rd_q, mode);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                wr_q <= bump(wr_q, mode);
            end
            if (pop) begin
                rd_q <= bump(rd_q, mode);
            end
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= limit); // R1

    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> (cnt_q != '0)); // R3

    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt_q < limit)); // R1

endmodule

// File: rtl/dtq_store.sv
module dtq_store #(
    parameter int DEPTH = 16,
    parameter int EW    = 33
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [EW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [EW-1:0]            rdata
);

    logic [EW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/dual_thread_uop_queue.sv
module dual_thread_uop_queue
    import dtq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int PAYLOAD_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode_req,
    output logic                 mode_st,
    input  logic                 t0_in_valid,
    input  logic [PAYLOAD_W-1:0] t0_in_data,
    output logic                 t0_in_ready,
    input  logic                 t1_in_valid,
    input  logic [PAYLOAD_W-1:0] t1_in_data,
    output logic                 t1_in_ready,
    output logic                 deq_valid,
    output logic                 deq_tid,
    output logic [PAYLOAD_W-1:0] deq_data,
    input  logic                 deq_ready
);

    localparam int AW = $clog2(DEPTH);
    localparam int EW = PAYLOAD_W + 1;

    typedef struct packed {
        tid_e                 tid;
        logic [PAYLOAD_W-1:0] data;
    } entry_t;

    mode_e            mode_q;
    logic             pending, drained, switch_now;
    logic [1:0]       in_valid, room, nonempty, enq_req, enq_gnt, acc;
    logic [1:0]       deq_gnt, pop;
    logic [AW-1:0]    wr_addr [2];
    logic [AW-1:0]    rd_addr [2];
    logic [PAYLOAD_W-1:0] in_data [2];
    logic [1:0]       in_ready;
    tid_e             enq_last, deq_last;
    logic             deq_fire;
    entry_t           wr_ent, rd_ent;
    logic [AW-1:0]    waddr, raddr;

    assign in_valid   = {t1_in_valid, t0_in_valid};
    assign in_data[0] = t0_in_data;
    assign in_data[1] = t1_in_data;

    // mode control: apply only across an empty queue
    assign pending    = (mode_e'(mode_req) != mode_q);
    assign drained    = (nonempty == 2'b00);
    assign switch_now = pending && drained;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_SPLIT;
        end else if (switch_now) begin
            mode_q <= mode_e'(mode_req);
        end
    end

    assign mode_st = mode_q;

    // per-thread pointer and occupancy state
    for (genvar t = 0; t < 2; t++) begin : g_thr
        dtq_thread_ctl #(
            .DEPTH (DEPTH),
            .TID   (t)
        ) i_ctl (
            .clk      (clk),
            .rst      (rst),
            .clr      (switch_now),
            .mode     (mode_q),
            .push     (acc[t]),
            .pop      (pop[t]),
            .wr_addr  (wr_addr[t]),
            .rd_addr  (rd_addr[t]),
            .room     (room[t]),
            .nonempty (nonempty[t])
        );

        assign enq_req[t]  = in_valid[t] && room[t] && !pending;
        assign in_ready[t] = room[t] && !pending &&
                             !(enq_req[peer(t)] && (enq_last == tid_e'(t)));
        assign acc[t]      = enq_req[t] && enq_gnt[t];
        assign pop[t]      = deq_fire && deq_gnt[t];
    end

    assign t0_in_ready = in_ready[0];
    assign t1_in_ready = in_ready[1];

    // enqueue side turn-taking
    dtq_rr_arb i_enq_arb (
        .clk    (clk),
        .rst    (rst),
        .req    (enq_req),
        .fire   (|acc),
        .gnt    (enq_gnt),
        .last_q (enq_last)
    );

    // dequeue side turn-taking
    dtq_rr_arb i_deq_arb (
        .clk    (clk),
        .rst    (rst),
        .req    (nonempty),
        .fire   (deq_fire),
        .gnt    (deq_gnt),
        .last_q (deq_last)
    );

    assign wr_ent.tid  = acc[1] ? TID1 : TID0;
    assign wr_ent.data = acc[1] ? in_data[1] : in_data[0];
    assign waddr       = acc[1] ? wr_addr[1] : wr_addr[0];
    assign raddr       = deq_gnt[1] ? rd_addr[1] : rd_addr[0];

    dtq_store #(
        .DEPTH (DEPTH),
        .EW    (EW)
    ) i_store (
        .clk   (clk),
        .we    (|acc),
        .waddr (waddr),
        .wdata (wr_ent),
        .raddr (raddr),
        .rdata (rd_ent)
    );

    assign deq_valid = |nonempty;
    assign deq_tid   = rd_ent.tid;
    assign deq_data  = rd_ent.data;
    assign deq_fire  = deq_valid && deq_ready;

    AST_MODE_DRAINED: assert property (@(posedge clk) disable iff (rst)
        (mode_q != $past(mode_q)) |-> $past(nonempty == 2'b00)); // R6

    AST_SOLO_T1_HELD: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SOLO) |-> !t1_in_ready); // R2

    AST_PENDING_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        pending |-> !(t0_in_ready || t1_in_ready)); // R6

    AST_TID_MATCH: assert property (@(posedge clk) disable iff (rst)
        deq_fire |-> (deq_tid == deq_gnt[1])); // R3

    AST_LONE_SERVED: assert property (@(posedge clk) disable iff (rst)
        (deq_valid && nonempty != 2'b11) |-> (deq_gnt == nonempty)); // R4

    initial begin
        assert (DEPTH >= 4 && (DEPTH & (DEPTH - 1)) == 0);
    end

endmodule

// File: tb/test_dual_thread_uop_queue.sv
module test_dual_thread_uop_queue;

    localparam int DEPTH = 16;
    localparam int W     = 8;
    localparam int NROW  = 6;

    // row: {v0, v1, r0, r1, d0[7:0], d1[7:0]}
    localparam logic [19:0] TBL [NROW] = '{
        {1'b1, 1'b1, 1'b1, 1'b0, 8'h10, 8'h20},
        {1'b1, 1'b1, 1'b0, 1'b1, 8'h11, 8'h20},
        {1'b1, 1'b0, 1'b1, 1'b0, 8'h11, 8'h00},
        {1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h21},
        {1'b1, 1'b1, 1'b1, 1'b0, 8'h12, 8'h22},
        {1'b1, 1'b0, 1'b1, 1'b1, 8'h13, 8'h00}
    };

    logic         clk = 1'b0;
    logic         rst;
    logic         mode_req, mode_st;
    logic         t0_in_valid, t0_in_ready, t1_in_valid, t1_in_ready;
    logic [W-1:0] t0_in_data, t1_in_data, deq_data;
    logic         deq_valid, deq_tid, deq_ready;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dual_thread_uop_queue #(
        .DEPTH     (DEPTH),
        .PAYLOAD_W (W)
    ) i_dual_thread_uop_queue (
        .clk         (clk),
        .rst         (rst),
        .mode_req    (mode_req),
        .mode_st     (mode_st),
        .t0_in_valid (t0_in_valid),
        .t0_in_data  (t0_in_data),
        .t0_in_ready (t0_in_ready),
        .t1_in_valid (t1_in_valid),
        .t1_in_data  (t1_in_data),
        .t1_in_ready (t1_in_ready),
        .deq_valid   (deq_valid),
        .deq_tid     (deq_tid),
        .deq_data    (deq_data),
        .deq_ready   (deq_ready)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push0(input logic [W-1:0] d, input string req);
        t0_in_valid = 1'b1;
        t0_in_data  = d;
        @(negedge clk);
        chk(req, "t0 ready on push", int'(t0_in_ready), 1);
        step();
        t0_in_valid = 1'b0;
    endtask

    task automatic pop_chk(input int et, input logic [W-1:0] ed, input string req);
        deq_ready = 1'b1;
        @(negedge clk);
        chk(req, "deq_valid", int'(deq_valid), 1);
        chk(req, "deq_tid", int'(deq_tid), et);
        chk(req, "deq_data", int'(deq_data), int'(ed));
        step();
        deq_ready = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst         = 1'b1;
        mode_req    = 1'b0;
        t0_in_valid = 1'b0;
        t1_in_valid = 1'b0;
        t0_in_data  = '0;
        t1_in_data  = '0;
        deq_ready   = 1'b0;
        repeat (3) step();
        rst = 1'b0;

        // R7 reset state
        @(negedge clk);
        chk("R7", "deq_valid", int'(deq_valid), 0);
        chk("R7", "mode_st", int'(mode_st), 0);
        chk("R7", "t0 ready", int'(t0_in_ready), 1);
        chk("R7", "t1 ready", int'(t1_in_ready), 1);
        step();

        // R5 enqueue turn-taking table
        for (int i = 0; i < NROW; i++) begin
            t0_in_valid = TBL[i][19];
            t1_in_valid = TBL[i][18];
            t0_in_data  = TBL[i][15:8];
            t1_in_data  = TBL[i][7:0];
            @(negedge clk);
            chk("R5", $sformatf("row %0d t0 ready", i), int'(t0_in_ready), int'(TBL[i][17]));
            chk("R5", $sformatf("row %0d t1 ready", i), int'(t1_in_ready), int'(TBL[i][16]));
            step();
            t0_in_valid = 1'b0;
            t1_in_valid = 1'b0;
        end

        // R4 dequeue alternation then fall-through, R3 order
        pop_chk(0, 8'h10, "R4");
        pop_chk(1, 8'h20, "R4");
        pop_chk(0, 8'h11, "R3");
        pop_chk(1, 8'h21, "R3");
        pop_chk(0, 8'h12, "R4");
        pop_chk(0, 8'h13, "R4");
        @(negedge clk);
        chk("R4", "empty after drain", int'(deq_valid), 0);
        step();

        // R1 half limit in split mode
        for (int i = 0; i < DEPTH / 2; i++) begin
            push0(8'(8'h40 + i), "R1");
        end
        t0_in_valid = 1'b1;
        t0_in_data  = 8'hEE;
        t1_in_valid = 1'b1;
        t1_in_data  = 8'h55;
        @(negedge clk);
        chk("R1", "t0 ready at half", int'(t0_in_ready), 0);
        chk("R1", "t1 ready with own room", int'(t1_in_ready), 1);
        step();
        t0_in_valid = 1'b0;
        t1_in_valid = 1'b0;
        pop_chk(1, 8'h55, "R4");
        for (int i = 0; i < DEPTH / 2; i++) begin
            pop_chk(0, 8'(8'h40 + i), "R3");
        end

        // R6 mode change deferred until empty
        push0(8'h60, "R6");
        mode_req    = 1'b1;
        t0_in_valid = 1'b1;
        t0_in_data  = 8'h61;
        @(negedge clk);
        chk("R6", "t0 ready while pending", int'(t0_in_ready), 0);
        chk("R6", "t1 ready while pending", int'(t1_in_ready), 0);
        chk("R6", "mode held", int'(mode_st), 0);
        t0_in_valid = 1'b0;
        step();
        pop_chk(0, 8'h60, "R6");
        @(negedge clk);
        chk("R6", "mode one edge after drain", int'(mode_st), 0);
        step();
        @(negedge clk);
        chk("R6", "mode applied", int'(mode_st), 1);

        // R2 solo mode uses all entries
        step();
        for (int i = 0; i < DEPTH; i++) begin
            t1_in_valid = 1'b1;
            push0(8'(8'h70 + i), "R2");
            chk("R2", "t1 held in solo", int'(t1_in_ready), 0);
        end
        t0_in_valid = 1'b1;
        t1_in_valid = 1'b1;
        @(negedge clk);
        chk("R2", "t0 ready when full", int'(t0_in_ready), 0);
        chk("R2", "t1 ready when full", int'(t1_in_ready), 0);
        step();
        t0_in_valid = 1'b0;
        t1_in_valid = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            pop_chk(0, 8'(8'h70 + i), "R2");
        end

        // back to split mode, empty so applied at next edge
        mode_req = 1'b0;
        @(negedge clk);
        chk("R6", "mode before switch back", int'(mode_st), 1);
        chk("R6", "t0 ready pending back", int'(t0_in_ready), 0);
        step();
        @(negedge clk);
        chk("R6", "mode back to split", int'(mode_st), 0);
        step();

        // R8 one-edge latency
        t1_in_valid = 1'b1;
        t1_in_data  = 8'h99;
        @(negedge clk);
        chk("R8", "deq_valid before edge", int'(deq_valid), 0);
        chk("R8", "t1 ready", int'(t1_in_ready), 1);
        step();
        t1_in_valid = 1'b0;
        pop_chk(1, 8'h99, "R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule